// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns single-byte requests from a flash controller into raw NAND bus cycles. Each request names one of four cycle kinds: command latch, address latch, data write or data read. It carries one byte. The block drives the command-latch and address-latch enables, the active-low write and read strobes, and the byte-wide I/O bus with its output enable. On a data read it returns the captured byte with a one-clock valid pulse.

All bus timing is counted in controller periods. One controller period is `SUBPH` cycles of `clk`, which is four by default. The four quarter steps of a period are what allow half-period strobe pulses and quarter-period data setup and hold in a design that uses a single clock edge.

Command and address cycles follow one of two profiles, fast or extended. The profile is taken from `cfg_ext` at the moment the request is accepted. Data cycles always take one period each, so a stream of back-to-back requests moves one byte per period.

Top module: `nand_cycle_seq`

## Requirements
- R1: While reset is applied and afterwards until the first request, the block is idle: `cmd_latch` and `addr_latch` are 0, `wr_strobe_n` and `rd_strobe_n` are 1, `io_oe` is 0, `rd_valid` is 0 and `req_ready` is 1.
- R2: A fast command or address cycle lasts 3 periods (12 clocks), counted from the clock after acceptance. The latch enable is high for all 12 clocks. The bus is driven from clock 4 onward. The write strobe is low during clocks 4 to 7, which gives a latch setup of 2 periods, a strobe low time of 1 period, a data setup of 1 period and a hold of 1 period.
- R3: An extended command or address cycle lasts 6 periods (24 clocks). The latch enable is high for all 24 clocks. The bus is driven from clock 4 onward. The write strobe is low during clocks 8 to 15, which gives a latch setup of 4 periods, a strobe low time of 2 periods, a data setup of 3 periods and a hold of 2 periods.
- R4: `req_kind` 0 is a command cycle and raises only `cmd_latch`. `req_kind` 1 is an address cycle and raises only `addr_latch`. The two latch enables are never high together, and both stay low during data cycles.
- R5: The profile is taken from `cfg_ext` (0 fast, 1 extended) on the clock that accepts a request. A change of `cfg_ext` during a cycle does not alter that cycle.
- R6: `req_kind` 2 is a data write of 1 period. The bus carries the byte for all 4 quarters. The write strobe is low in quarters 1 and 2 only, so the data is set up 3/4 period before the strobe rises and held 1/4 period after it.
- R7: `req_kind` 3 is a data read of 1 period. The read strobe is low in quarters 1 and 2. `io_in` is sampled on the clock edge where the read strobe rises. The sampled byte appears on `rd_data` with `rd_valid` high for exactly one clock, in quarter 3.
- R8: `req_ready` is high only when the block is idle or in the last clock of a cycle. A request held while `req_ready` is low is not taken. Back-to-back requests therefore start with no gap.
- R9: `io_in` is ignored outside read sampling. Any value on it during write, command or address cycles produces no `rd_valid`.
- R10: `io_oe` is low when idle and during reads. In command and address cycles, `io_oe` is high from the data-setup window through the end of the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, SUBPH cycles per controller period |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ext | input | 1 | Profile select for command/address cycles: 1 extended, 0 fast |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted on a clock where both valid and ready are high |
| req_kind | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| req_byte | input | 8 | Byte for command, address or write cycles |
| rd_valid | output | 1 | One-clock pulse with a read byte |
| rd_data | output | 8 | Byte captured by the last read cycle |
| cmd_latch | output | 1 | Command latch enable to flash |
| addr_latch | output | 1 | Address latch enable to flash |
| wr_strobe_n | output | 1 | Active-low write strobe to flash |
| rd_strobe_n | output | 1 | Active-low read strobe to flash |
| io_out | output | 8 | Byte driven toward flash |
| io_oe | output | 1 | Output enable for the I/O bus |
| io_in | input | 8 | Byte received from flash |

## Verification
The bench aims at the points where the strobe edges fall. It compares every clock of each cycle against a timeline built from the requirements, so a strobe that is one quarter early or late, or a setup window that is one period too short, shows up as a mismatch on a named clock.

A profile change that arrives while a cycle is running is used to catch a design that reads `cfg_ext` live rather than at acceptance. Such a design would stretch or shrink a cycle in flight.

Back-to-back bursts catch two faults. A ready that opens a clock early drops or overlaps bytes. A ready that opens a clock late inserts idle gaps. Read bursts change `io_in` every period to catch sampling on the wrong quarter. Write bursts put a junk value on `io_in` to catch a design that sets `rd_valid` outside a read.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    CYC_CMD  = 2'd0,
    CYC_ADDR = 2'd1,
    CYC_WR   = 2'd2,
    CYC_RD   = 2'd3
  } cyc_kind_e;

  // Segments of a bus cycle; command/address cycles walk LEAD..HOLD,
  // data cycles spend a single period in BYTE.
  typedef enum logic [2:0] {
    SEG_IDLE   = 3'd0,
    SEG_LEAD   = 3'd1,
    SEG_SETUP  = 3'd2,
    SEG_STROBE = 3'd3,
    SEG_HOLD   = 3'd4,
    SEG_BYTE   = 3'd5
  } seg_e;

  typedef struct packed {
    cyc_kind_e         kind;
    logic              ext;
    logic [BYTE_W-1:0] data;
  } cyc_req_t;

endpackage

// File: rtl/nseq_sub_counter.sv
module nseq_sub_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_n;

  always_comb begin
    if (restart) cnt_n = '0;
    else         cnt_n = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

endmodule

// File: rtl/nseq_ctl.sv
module nseq_ctl
  import nand_seq_pkg::*;
#(
  parameter int SUBPH         = 4,
  parameter int LEAD_P        = 1,
  parameter int FAST_SETUP_P  = 0,
  parameter int FAST_STROBE_P = 1,
  parameter int FAST_HOLD_P   = 1,
  parameter int EXT_SETUP_P   = 1,
  parameter int EXT_STROBE_P  = 2,
  parameter int EXT_HOLD_P    = 2,
  parameter int CNT_W         = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  cyc_kind_e         req_kind,
  input  logic [BYTE_W-1:0] req_byte,
  input  logic              cfg_ext,
  input  logic [CNT_W-1:0]  cnt,
  output logic              req_ready,
  output logic              restart,
  output seg_e              seg,
  output cyc_req_t          cur
);

  seg_e     seg_n;
  cyc_req_t cur_n;
  logic     seg_last;
  logic     accept;
  logic     data_req;

  // Length of a segment in clk cycles for the profile latched with the cycle.
  function automatic int seg_clks(seg_e s, logic ext);
    int len;
    case (s)
      SEG_LEAD:   len = LEAD_P * SUBPH;
      SEG_SETUP:  len = (ext ? EXT_SETUP_P  : FAST_SETUP_P)  * SUBPH;
      SEG_STROBE: len = (ext ? EXT_STROBE_P : FAST_STROBE_P) * SUBPH;
      SEG_HOLD:   len = (ext ? EXT_HOLD_P   : FAST_HOLD_P)   * SUBPH;
      SEG_BYTE:   len = SUBPH;
      default:    len = 1;
    endcase
    return len;
  endfunction

  // Next-state process
  always_comb begin
    seg_last  = (int'(cnt) == seg_clks(seg, cur.ext) - 1);
    req_ready = (seg == SEG_IDLE) ||
                (seg_last && ((seg == SEG_HOLD) || (seg == SEG_BYTE)));
    accept    = req_ready && req_valid;
    data_req  = (req_kind == CYC_WR) || (req_kind == CYC_RD);
    seg_n     = seg;
    cur_n     = cur;

    case (seg)
      SEG_LEAD: begin
        if (seg_last)
          seg_n = (seg_clks(SEG_SETUP, cur.ext) == 0) ? SEG_STROBE : SEG_SETUP;
      end
      SEG_SETUP: begin
        if (seg_last) seg_n = SEG_STROBE;
      end
      SEG_STROBE: begin
        if (seg_last) seg_n = SEG_HOLD;
      end
      SEG_HOLD, SEG_BYTE: begin
        if (seg_last) seg_n = SEG_IDLE;
      end
      default: seg_n = SEG_IDLE;
    endcase

    if (accept) begin
      seg_n      = data_req ? SEG_BYTE : SEG_LEAD;
      cur_n.kind = req_kind;
      cur_n.ext  = cfg_ext;
      cur_n.data = req_byte;
    end

    restart = (seg == SEG_IDLE) || seg_last;
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg <= SEG_IDLE;
      cur <= '{kind: CYC_CMD, ext: 1'b0, data: '0};
    end else begin
      seg <= seg_n;
      if (accept) cur <= cur_n;
    end
  end

endmodule

// File: rtl/nseq_pins.sv
module nseq_pins
  import nand_seq_pkg::*;
#(
  parameter int SUBPH = 4,
  parameter int CNT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seg_e              seg,
  input  cyc_req_t          cur,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [BYTE_W-1:0] io_in,
  output logic              cmd_latch,
  output logic              addr_latch,
  output logic              wr_strobe_n,
  output logic              rd_strobe_n,
  output logic              io_oe,
  output logic [BYTE_W-1:0] io_out,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data
);

  localparam int QTR       = SUBPH / 4;
  localparam int HALF      = SUBPH / 2;
  localparam int LOW_FIRST = QTR;
  localparam int LOW_LAST  = QTR + HALF - 1;

  logic in_ca;
  logic byte_low;
  logic capture;
  logic rd_valid_n;

  always_comb begin
    in_ca    = (seg == SEG_LEAD) || (seg == SEG_SETUP) ||
               (seg == SEG_STROBE) || (seg == SEG_HOLD);
    byte_low = (seg == SEG_BYTE) &&
               (int'(cnt) >= LOW_FIRST) && (int'(cnt) <= LOW_LAST);

    cmd_latch   = in_ca && (cur.kind == CYC_CMD);
    addr_latch  = in_ca && (cur.kind == CYC_ADDR);
    wr_strobe_n = !((seg == SEG_STROBE) || (byte_low && (cur.kind == CYC_WR)));
    rd_strobe_n = !(byte_low && (cur.kind == CYC_RD));
    io_oe       = (seg == SEG_SETUP) || (seg == SEG_STROBE) || (seg == SEG_HOLD) ||
                  ((seg == SEG_BYTE) && (cur.kind == CYC_WR));
    io_out      = cur.data;

    // Sample on the edge where the read strobe rises.
    capture     = (seg == SEG_BYTE) && (cur.kind == CYC_RD) && (int'(cnt) == LOW_LAST);
    rd_valid_n  = capture;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_valid_n;
      if (capture) rd_data <= io_in;
    end
  end

endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
  import nand_seq_pkg::*;
#(
  parameter int SUBPH         = 4,
  parameter int LEAD_P        = 1,
  parameter int FAST_SETUP_P  = 0,
  parameter int FAST_STROBE_P = 1,
  parameter int FAST_HOLD_P   = 1,
  parameter int EXT_SETUP_P   = 1,
  parameter int EXT_STROBE_P  = 2,
  parameter int EXT_HOLD_P    = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ext,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [BYTE_W-1:0] req_byte,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data,
  output logic              cmd_latch,
  output logic              addr_latch,
  output logic              wr_strobe_n,
  output logic              rd_strobe_n,
  output logic [BYTE_W-1:0] io_out,
  output logic              io_oe,
  input  logic [BYTE_W-1:0] io_in
);

  localparam int SPAN  = (LEAD_P + FAST_SETUP_P + FAST_STROBE_P + FAST_HOLD_P +
                          EXT_SETUP_P + EXT_STROBE_P + EXT_HOLD_P + 1) * SUBPH;
  localparam int CNT_W = $clog2(SPAN + 1);

  // Reset: asserted asynchronously, released through a synchronizer.
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_pipe[SYNC_STAGES-1];

  logic             restart;
  logic [CNT_W-1:0] cnt;
  seg_e             seg;
  cyc_req_t         cur;

  nseq_sub_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .restart (restart),
    .cnt     (cnt)
  );

  nseq_ctl #(
    .SUBPH         (SUBPH),
    .LEAD_P        (LEAD_P),
    .FAST_SETUP_P  (FAST_SETUP_P),
    .FAST_STROBE_P (FAST_STROBE_P),
    .FAST_HOLD_P   (FAST_HOLD_P),
    .EXT_SETUP_P   (EXT_SETUP_P),
    .EXT_STROBE_P  (EXT_STROBE_P),
    .EXT_HOLD_P    (EXT_HOLD_P),
    .CNT_W         (CNT_W)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .req_valid (req_valid),
    .req_kind  (cyc_kind_e'(req_kind)),
    .req_byte  (req_byte),
    .cfg_ext   (cfg_ext),
    .cnt       (cnt),
    .req_ready (req_ready),
    .restart   (restart),
    .seg       (seg),
    .cur       (cur)
  );

  nseq_pins #(.SUBPH(SUBPH), .CNT_W(CNT_W)) u_pins (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .seg         (seg),
    .cur         (cur),
    .cnt         (cnt),
    .io_in       (io_in),
    .cmd_latch   (cmd_latch),
    .addr_latch  (addr_latch),
    .wr_strobe_n (wr_strobe_n),
    .rd_strobe_n (rd_strobe_n),
    .io_oe       (io_oe),
    .io_out      (io_out),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data)
  );

endmodule

// File: rtl/nand_cycle_seq_chk.sv
module nand_cycle_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       rd_valid,
  input logic       cmd_latch,
  input logic       addr_latch,
  input logic       wr_strobe_n,
  input logic       rd_strobe_n,
  input logic [7:0] io_out,
  input logic       io_oe
);

  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_latch && addr_latch)); // R4

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wr_strobe_n && !rd_strobe_n)); // R6

  AST_WR_LOW_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe_n |-> io_oe); // R6

  AST_WR_LOW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_strobe_n && $past(!wr_strobe_n)) |-> $stable(io_out)); // R6

  AST_RD_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe_n |-> !io_oe); // R10

  AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R7

  AST_RDV_AFTER_RE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(!rd_strobe_n) && rd_strobe_n)); // R7

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (wr_strobe_n && rd_strobe_n)); // R8

endmodule

bind nand_cycle_seq nand_cycle_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rd_valid    (rd_valid),
  .cmd_latch   (cmd_latch),
  .addr_latch  (addr_latch),
  .wr_strobe_n (wr_strobe_n),
  .rd_strobe_n (rd_strobe_n),
  .io_out      (io_out),
  .io_oe       (io_oe)
);

// File: tb/nand_cycle_seq_test.sv
module nand_cycle_seq_test;

  logic       clk;
  logic       rst_n;
  logic       cfg_ext;
  logic       req_valid;
  logic       req_ready;
  logic [1:0] req_kind;
  logic [7:0] req_byte;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       cmd_latch;
  logic       addr_latch;
  logic       wr_strobe_n;
  logic       rd_strobe_n;
  logic [7:0] io_out;
  logic       io_oe;
  logic [7:0] io_in;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  nand_cycle_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_ext(cfg_ext), .req_valid(req_valid),
    .req_ready(req_ready), .req_kind(req_kind), .req_byte(req_byte),
    .rd_valid(rd_valid), .rd_data(rd_data), .cmd_latch(cmd_latch),
    .addr_latch(addr_latch), .wr_strobe_n(wr_strobe_n), .rd_strobe_n(rd_strobe_n),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Request list and expected per-clock timeline.
  // ctl vector bits: {ready, cmd_latch, addr_latch, wr_n, rd_n, oe, rd_valid}
  logic [1:0] q_kind [0:63];
  logic [7:0] q_byte [0:63];
  logic       q_ext  [0:63];
  int         n_req;
  logic [6:0] e_ctl  [0:511];
  logic [7:0] e_out  [0:511];
  logic [7:0] e_rd   [0:511];
  logic [7:0] drv_in [0:511];
  int         n_exp;
  event       acc_ev;

  task automatic check(string tag, bit ok, string what);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s", tag, what);
    end
  endtask

  function automatic void clear_seq();
    n_req = 0;
    n_exp = 0;
  endfunction

  function automatic void push(logic [6:0] c, logic [7:0] o, logic [7:0] r, logic [7:0] d);
    e_ctl[n_exp]  = c;
    e_out[n_exp]  = o;
    e_rd[n_exp]   = r;
    drv_in[n_exp] = d;
    n_exp++;
  endfunction

  // Command (0) or address (1) cycle: lead 1 period, setup 0/1, strobe 1/2, hold 1/2.
  function automatic void add_ca(logic [1:0] k, logic [7:0] b, logic ext);
    int lead = 4;
    int su   = ext ? 4 : 0;
    int lo   = ext ? 8 : 4;
    int hd   = ext ? 8 : 4;
    int tot  = lead + su + lo + hd;
    q_kind[n_req] = k; q_byte[n_req] = b; q_ext[n_req] = ext; n_req++;
    for (int j = 0; j < tot; j++) begin
      logic we_low;
      we_low = (j >= lead + su) && (j < lead + su + lo);
      push({(j == tot - 1), (k == 2'd0), (k == 2'd1), !we_low, 1'b1, (j >= lead), 1'b0},
           b, 8'h00, 8'hC3);
    end
  endfunction

  // Data write (2) or read (3): one period of four quarters.
  function automatic void add_data(logic [1:0] k, logic [7:0] b, logic ext);
    bit wr = (k == 2'd2);
    q_kind[n_req] = k; q_byte[n_req] = b; q_ext[n_req] = ext; n_req++;
    for (int s = 0; s < 4; s++) begin
      logic low;
      low = (s == 1) || (s == 2);
      push({(s == 3), 1'b0, 1'b0, !(wr && low), !(!wr && low), wr, (!wr && s == 3)},
           b, b, wr ? ~b : b);
    end
  endfunction

  function automatic void add_idle();
    push(7'b1001100, 8'h00, 8'h00, 8'h96);
  endfunction

  task automatic drive_all();
    for (int i = 0; i < n_req; i++) begin
      @(negedge clk);
      req_valid = 1'b1;
      req_kind  = q_kind[i];
      req_byte  = (q_kind[i] == 2'd3) ? 8'h00 : q_byte[i];
      cfg_ext   = q_ext[i];
      #1;
      while (!req_ready) begin
        @(negedge clk);
        #1;
      end
      @(posedge clk);
      if (i == 0) ->acc_ev;
    end
    @(negedge clk);
    req_valid = 1'b0;
    cfg_ext   = !q_ext[n_req - 1];
  endtask

  task automatic watch_all(string tag);
    @(acc_ev);
    for (int j = 0; j < n_exp; j++) begin
      logic [6:0] act;
      bit ok;
      @(negedge clk);
      io_in = drv_in[j];
      #1;
      act = {req_ready, cmd_latch, addr_latch, wr_strobe_n, rd_strobe_n, io_oe, rd_valid};
      ok = (act == e_ctl[j]);
      if (e_ctl[j][1] && io_out !== e_out[j]) ok = 0;
      if (e_ctl[j][0] && rd_data !== e_rd[j]) ok = 0;
      check(tag, ok, $sformatf("clk %0d: ctl=%b exp=%b out=%h exp=%h rd=%h exp=%h",
            j, act, e_ctl[j], io_out, e_out[j], rd_data, e_rd[j]));
    end
  endtask

  task automatic run_seq(string tag);
    add_idle();
    fork
      drive_all();
      watch_all(tag);
    join
    repeat (3) @(negedge clk);
  endtask

  // R1: idle state in reset and after release
  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'd0; req_byte = 8'h00;
    cfg_ext = 1'b0; io_in = 8'h00;
    repeat (3) @(negedge clk);
    check("R1", {req_ready, cmd_latch, addr_latch, wr_strobe_n, rd_strobe_n, io_oe, rd_valid}
          == 7'b1001100, $sformatf("in reset ctl=%b exp=1001100",
          {req_ready, cmd_latch, addr_latch, wr_strobe_n, rd_strobe_n, io_oe, rd_valid}));
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    #1;
    check("R1", {req_ready, cmd_latch, addr_latch, wr_strobe_n, rd_strobe_n, io_oe, rd_valid}
          == 7'b1001100, $sformatf("after reset ctl=%b exp=1001100",
          {req_ready, cmd_latch, addr_latch, wr_strobe_n, rd_strobe_n, io_oe, rd_valid}));
  endtask

  // R2, R4, R10: fast command then fast address
  task automatic t_fast_ca();
    clear_seq();
    add_ca(2'd0, 8'h80, 1'b0);
    add_ca(2'd1, 8'h12, 1'b0);
    run_seq("R2/R4/R10");
  endtask

  // R3, R4: extended command then extended address
  task automatic t_ext_ca();
    clear_seq();
    add_ca(2'd0, 8'h70, 1'b1);
    add_ca(2'd1, 8'h03, 1'b1);
    run_seq("R3/R4");
  endtask

  // R5: profile input flips while each cycle runs
  task automatic t_profile_switch();
    clear_seq();
    add_ca(2'd0, 8'h60, 1'b0);
    add_ca(2'd1, 8'h44, 1'b1);
    add_ca(2'd1, 8'h45, 1'b0);
    add_ca(2'd0, 8'hD0, 1'b1);
    run_seq("R5");
  endtask

  // R6, R9: write burst at one byte per period with junk on io_in
  task automatic t_write_burst();
    clear_seq();
    add_data(2'd2, 8'hA5, 1'b0);
    add_data(2'd2, 8'h5A, 1'b1);
    add_data(2'd2, 8'h00, 1'b0);
    add_data(2'd2, 8'hFF, 1'b0);
    add_data(2'd2, 8'h3C, 1'b1);
    run_seq("R6/R9");
  endtask

  // R7, R10: read burst with a new byte on io_in every period
  task automatic t_read_burst();
    clear_seq();
    add_data(2'd3, 8'h11, 1'b0);
    add_data(2'd3, 8'hEE, 1'b0);
    add_data(2'd3, 8'h72, 1'b1);
    add_data(2'd3, 8'h8D, 1'b0);
    run_seq("R7/R10");
  endtask

  // R8: mixed chain, ready gating between unlike cycles
  task automatic t_mixed();
    clear_seq();
    add_ca(2'd0, 8'h00, 1'b0);
    add_ca(2'd1, 8'h01, 1'b0);
    add_ca(2'd1, 8'h02, 1'b1);
    add_ca(2'd0, 8'h30, 1'b0);
    add_data(2'd3, 8'hB7, 1'b0);
    add_data(2'd2, 8'h29, 1'b0);
    add_data(2'd3, 8'h4E, 1'b1);
    add_ca(2'd0, 8'h10, 1'b1);
    run_seq("R8");
  endtask

  initial begin
    t_reset();
    t_fast_ca();
    t_ext_ca();
    t_profile_switch();
    t_write_burst();
    t_read_burst();
    t_mixed();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule